// File: doc/BRIEF.md
# Serial Port DMA Request Generator

This block drives the two request lines that a serial port presents to a DMA controller. One line asks the controller to read a received entry. The other asks it to write a new entry for transmission. Each line has its own selectable set of sources. They are built from these inputs:

- receive-buffer fill level
- a tag marking the head receive entry as right-channel audio
- transmit-buffer fill level
- a flag marking the next transmit slot as right-channel
- the shifter's busy flag

The configured transfer size decides whether one DMA beat moves one buffer entry or two. The level conditions take that into account.

Each request is held in a pending register per source. A pending bit stays set until the controller acknowledges, even if its source condition drops. An acknowledge on the write side clears the pending state of every write source, not only the selected one. As an option, a framing error can hold off all requests. They stay off until software issues a clear pulse.

Top module: `dma_req_gen`

## Requirements
- R1: After reset both `rdReq` and `wrReq` are low and the error hold is inactive.
- R2: With `cfgRdSrc`=0, the read source is true when `rxLevel` covers one transfer. One transfer takes 1 entry for `cfgXferSize` 0 (byte) or 1 (9-bit with status). It takes 2 entries for 2 (byte pair) or 3 (pair with status). `rdReq` rises in the cycle after the source becomes true.
- R3: With `cfgRdSrc`=1, the read source additionally needs `cfgI2sMode`=1 and `rxRightTag`=1. With `cfgI2sMode`=0 it never requests.
- R4: With `cfgWrSrc`=0, the write source is true when `txLevel` is 0 and `shiftBusy` is 0. A `cfgWrSrc` of 3 selects no source.
- R5: With `cfgWrSrc`=1, the write source is true when `TX_DEPTH - txLevel` is at least the entries one transfer takes (see R2).
- R6: With `cfgWrSrc`=2, the write source is the R5 condition together with `cfgI2sMode`=1 and `txRightSlot`=1.
- R7: Once asserted, a request stays high while its acknowledge is low, even if its source condition goes false.
- R8: A one-cycle acknowledge drives its request low in the following cycle. If the source is still true, the request returns one cycle later.
- R9: A `wrAck` clears the pending state of all write sources, and an `rdAck` clears both read sources. Changing the selection right after an acknowledge therefore shows no request until re-evaluation.
- R10: With `cfgErrStop`=1, a `frameErr` pulse forces both requests low from the next cycle on. They stay low until an `errClr` pulse. After that pulse the requests come back one cycle later than in R2 timing.
- R11: With `cfgErrStop`=0, `frameErr` has no effect on either request.
- R12: When `frameErr` (with `cfgErrStop`=1) and `errClr` arrive in the same cycle, the hold is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgI2sMode | input | 1 | Audio channel mode enable |
| cfgRdSrc | input | 1 | Read request source select |
| cfgWrSrc | input | 2 | Write request source select |
| cfgXferSize | input | 2 | Transfer size code |
| cfgErrStop | input | 1 | Hold requests after a framing error |
| rxLevel | input | $clog2(RX_DEPTH+1) | Receive buffer entries |
| rxRightTag | input | 1 | Head receive entry is right channel |
| txLevel | input | $clog2(TX_DEPTH+1) | Transmit buffer entries |
| txRightSlot | input | 1 | Next transmit slot is right channel |
| shiftBusy | input | 1 | Transmit shifter busy |
| frameErr | input | 1 | Framing error pulse |
| errClr | input | 1 | Software clear of the error hold |
| rdAck | input | 1 | Read request acknowledge |
| wrAck | input | 1 | Write request acknowledge |
| rdReq | output | 1 | Read request to DMA |
| wrReq | output | 1 | Write request to DMA |

## Verification
The bench places levels exactly at the one-entry and two-entry thresholds. A design that ignores the transfer size would request a pair with only one entry present or one slot free. It switches the write selection right after an acknowledge, so a design that clears only the selected source shows a request one cycle early. It checks that a request outlives its dropped condition, which catches a design that merely follows the condition. It also drives error and clear together and times the release of the hold, which exposes wrong priority or a stale pending bit escaping at release.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int RD_SRCS = 2;
  localparam int WR_SRCS = 3;

  typedef enum logic [1:0] {
    XFER_BYTE      = 2'd0,
    XFER_WIDE      = 2'd1,
    XFER_PAIR      = 2'd2,
    XFER_PAIR_WIDE = 2'd3
  } xferSize_e;

  typedef struct packed {
    logic clrRd;
    logic clrWr;
    logic gate;
  } reqStrobe_t;

  function automatic logic takesPair(input logic [1:0] size);
    return (size == XFER_PAIR) || (size == XFER_PAIR_WIDE);
  endfunction

endpackage

// File: rtl/dma_req_cond.sv
module dma_req_cond
  import dma_req_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  localparam int RX_LW = $clog2(RX_DEPTH + 1),
  localparam int TX_LW = $clog2(TX_DEPTH + 1)
) (
  input  logic [1:0]         cfgXferSize,
  input  logic               cfgI2sMode,
  input  logic [RX_LW-1:0]   rxLevel,
  input  logic               rxRightTag,
  input  logic [TX_LW-1:0]   txLevel,
  input  logic               txRightSlot,
  input  logic               shiftBusy,
  output logic [RD_SRCS-1:0] rdCond,
  output logic [WR_SRCS-1:0] wrCond
);

  logic             pairXfer;
  logic             rxEnough;
  logic             txEnough;
  logic [TX_LW-1:0] txFree;

  always_comb begin
    pairXfer = takesPair(cfgXferSize);
    rxEnough = pairXfer ? (rxLevel >= RX_LW'(2)) : (rxLevel != '0);
    txFree   = TX_LW'(TX_DEPTH) - txLevel;
    txEnough = pairXfer ? (txFree >= TX_LW'(2)) : (txFree != '0);

    rdCond[0] = rxEnough;
    rdCond[1] = rxEnough && rxRightTag && cfgI2sMode;

    wrCond[0] = (txLevel == '0) && !shiftBusy;
    wrCond[1] = txEnough;
    wrCond[2] = txEnough && txRightSlot && cfgI2sMode;
  end

endmodule

// File: rtl/dma_req_pend.sv
module dma_req_pend #(
  parameter int N_SRC = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] cond,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  input  logic             gate,
  output logic             req
);

  logic [N_SRC-1:0] pendQ;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       pendQ[i] <= 1'b0;
      else if (clr)    pendQ[i] <= 1'b0;
      else if (cond[i]) pendQ[i] <= 1'b1;
    end
  end

  always_comb begin
    req = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) req = pendQ[i];
    end
    if (gate) req = 1'b0;
  end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgErrStop,
  input  logic       frameErr,
  input  logic       errClr,
  input  logic       rdAck,
  input  logic       wrAck,
  output logic       holdQ,
  output reqStrobe_t strobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         holdQ <= 1'b0;
    else if (frameErr && cfgErrStop)   holdQ <= 1'b1;
    else if (errClr)                   holdQ <= 1'b0;
  end

  always_comb begin
    strobe.clrRd = rdAck || holdQ;
    strobe.clrWr = wrAck || holdQ;
    strobe.gate  = holdQ;
  end

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgI2sMode,
  input  logic                          cfgRdSrc,
  input  logic [1:0]                    cfgWrSrc,
  input  logic [1:0]                    cfgXferSize,
  input  logic                          cfgErrStop,
  input  logic [$clog2(RX_DEPTH+1)-1:0] rxLevel,
  input  logic                          rxRightTag,
  input  logic [$clog2(TX_DEPTH+1)-1:0] txLevel,
  input  logic                          txRightSlot,
  input  logic                          shiftBusy,
  input  logic                          frameErr,
  input  logic                          errClr,
  input  logic                          rdAck,
  input  logic                          wrAck,
  output logic                          rdReq,
  output logic                          wrReq
);

  logic [RD_SRCS-1:0] rdCond;
  logic [WR_SRCS-1:0] wrCond;
  logic               errHold;
  reqStrobe_t         strobe;

  dma_req_cond #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_cond (
    .cfgXferSize(cfgXferSize), .cfgI2sMode(cfgI2sMode),
    .rxLevel(rxLevel), .rxRightTag(rxRightTag),
    .txLevel(txLevel), .txRightSlot(txRightSlot), .shiftBusy(shiftBusy),
    .rdCond(rdCond), .wrCond(wrCond)
  );

  dma_req_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgErrStop(cfgErrStop),
    .frameErr(frameErr), .errClr(errClr),
    .rdAck(rdAck), .wrAck(wrAck),
    .holdQ(errHold), .strobe(strobe)
  );

  dma_req_pend #(.N_SRC(RD_SRCS), .SEL_W(1)) u_rdPend (
    .clk(clk), .rstN(rstN), .cond(rdCond), .sel(cfgRdSrc),
    .clr(strobe.clrRd), .gate(strobe.gate), .req(rdReq)
  );

  dma_req_pend #(.N_SRC(WR_SRCS), .SEL_W(2)) u_wrPend (
    .clk(clk), .rstN(rstN), .cond(wrCond), .sel(cfgWrSrc),
    .clr(strobe.clrWr), .gate(strobe.gate), .req(wrReq)
  );

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk (
  input logic clk,
  input logic rstN,
  input logic cfgErrStop,
  input logic cfgRdSrc,
  input logic frameErr,
  input logic errHold,
  input logic rdAck,
  input logic wrAck,
  input logic rdReq,
  input logic wrReq
);

  AST_HOLD_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    errHold |-> (!rdReq && !wrReq)); // R10

  AST_RD_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |=> !rdReq); // R8

  AST_WR_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    wrAck |=> !wrReq); // R8

  AST_RD_REQ_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && !(frameErr && cfgErrStop))
      |=> (rdReq || (cfgRdSrc != $past(cfgRdSrc)))); // R7

  AST_ERR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgErrStop && !errHold) |=> !errHold); // R11

  AST_ERR_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && cfgErrStop) |=> errHold); // R12

endmodule

bind dma_req_gen dma_req_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgErrStop(cfgErrStop), .cfgRdSrc(cfgRdSrc),
  .frameErr(frameErr), .errHold(errHold), .rdAck(rdAck), .wrAck(wrAck),
  .rdReq(rdReq), .wrReq(wrReq)
);

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;

  localparam int RX_DEPTH = 8;
  localparam int TX_DEPTH = 8;
  localparam int RX_LW = $clog2(RX_DEPTH + 1);
  localparam int TX_LW = $clog2(TX_DEPTH + 1);

  logic clk = 1'b0;
  logic rstN;
  logic cfgI2sMode, cfgRdSrc, cfgErrStop;
  logic [1:0] cfgWrSrc, cfgXferSize;
  logic [RX_LW-1:0] rxLevel;
  logic [TX_LW-1:0] txLevel;
  logic rxRightTag, txRightSlot, shiftBusy, frameErr, errClr, rdAck, wrAck;
  logic rdReq, wrReq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dma_req_gen #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) dut (
    .clk(clk), .rstN(rstN), .cfgI2sMode(cfgI2sMode), .cfgRdSrc(cfgRdSrc),
    .cfgWrSrc(cfgWrSrc), .cfgXferSize(cfgXferSize), .cfgErrStop(cfgErrStop),
    .rxLevel(rxLevel), .rxRightTag(rxRightTag), .txLevel(txLevel),
    .txRightSlot(txRightSlot), .shiftBusy(shiftBusy), .frameErr(frameErr),
    .errClr(errClr), .rdAck(rdAck), .wrAck(wrAck), .rdReq(rdReq), .wrReq(wrReq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cfgI2sMode = 0; cfgRdSrc = 0; cfgWrSrc = 2'd0; cfgXferSize = 2'd0;
    cfgErrStop = 0; rxLevel = '0; rxRightTag = 0;
    txLevel = TX_LW'(TX_DEPTH); txRightSlot = 0; shiftBusy = 1;
    frameErr = 0; errClr = 0; rdAck = 0; wrAck = 0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic tReset();
    doReset();
    chk("R1 rdReq", rdReq, 1'b0);
    chk("R1 wrReq", wrReq, 1'b0);
  endtask

  task automatic tReadLevel();
    doReset();
    cfgXferSize = 2'd2; rxLevel = RX_LW'(1);
    cyc(2);
    chk("R2 pair with one entry", rdReq, 1'b0);
    cfgXferSize = 2'd3;
    cyc(2);
    chk("R2 pair-status with one entry", rdReq, 1'b0);
    cfgXferSize = 2'd1;
    cyc(1);
    chk("R2 wide with one entry", rdReq, 1'b1);
    doReset();
    cfgXferSize = 2'd2; rxLevel = RX_LW'(2);
    cyc(1);
    chk("R2 pair with two entries", rdReq, 1'b1);
  endtask

  task automatic tReadRight();
    doReset();
    cfgRdSrc = 1; rxLevel = RX_LW'(2); rxRightTag = 1;
    cyc(2);
    chk("R3 right source without i2s", rdReq, 1'b0);
    cfgI2sMode = 1; rxRightTag = 0;
    cyc(2);
    chk("R3 right source left data", rdReq, 1'b0);
    rxRightTag = 1;
    cyc(1);
    chk("R3 right source right data", rdReq, 1'b1);
  endtask

  task automatic tWriteEmpty();
    doReset();
    cfgWrSrc = 2'd0; txLevel = '0; shiftBusy = 1;
    cyc(2);
    chk("R4 shifter busy", wrReq, 1'b0);
    cfgWrSrc = 2'd3; shiftBusy = 0;
    cyc(2);
    chk("R4 reserved select", wrReq, 1'b0);
    cfgWrSrc = 2'd0;
    #1;
    chk("R4 all idle", wrReq, 1'b1);
  endtask

  task automatic tWriteRoom();
    doReset();
    cfgWrSrc = 2'd1; cfgXferSize = 2'd2; txLevel = TX_LW'(TX_DEPTH - 1);
    cyc(2);
    chk("R5 pair with one free", wrReq, 1'b0);
    txLevel = TX_LW'(TX_DEPTH - 2);
    cyc(1);
    chk("R5 pair with two free", wrReq, 1'b1);
  endtask

  task automatic tWriteRight();
    doReset();
    cfgWrSrc = 2'd2; txLevel = TX_LW'(TX_DEPTH - 1); cfgI2sMode = 1; txRightSlot = 0;
    cyc(2);
    chk("R6 left slot", wrReq, 1'b0);
    txRightSlot = 1;
    cyc(1);
    chk("R6 right slot", wrReq, 1'b1);
  endtask

  task automatic tStickyAndAck();
    doReset();
    rxLevel = RX_LW'(1);
    cyc(1);
    chk("R7 raised", rdReq, 1'b1);
    rxLevel = '0;
    cyc(3);
    chk("R7 held after source drop", rdReq, 1'b1);
    rdAck = 1;
    cyc(1);
    rdAck = 0;
    chk("R8 low after ack", rdReq, 1'b0);
    cyc(2);
    chk("R8 stays low without source", rdReq, 1'b0);
    rxLevel = RX_LW'(3);
    cyc(1);
    rdAck = 1;
    cyc(1);
    rdAck = 0;
    chk("R8 low after ack with source", rdReq, 1'b0);
    cyc(1);
    chk("R8 reasserts", rdReq, 1'b1);
  endtask

  task automatic tClearBoth();
    doReset();
    txLevel = '0; shiftBusy = 0; cfgWrSrc = 2'd0;
    cyc(2);
    cfgWrSrc = 2'd1;
    #1;
    chk("R9 other source pending", wrReq, 1'b1);
    wrAck = 1;
    cyc(1);
    wrAck = 0; cfgWrSrc = 2'd0;
    #1;
    chk("R9 other source cleared by ack", wrReq, 1'b0);
    cyc(1);
    chk("R9 re-evaluated", wrReq, 1'b1);
    doReset();
    cfgI2sMode = 1; rxRightTag = 1; rxLevel = RX_LW'(1);
    cyc(2);
    rdAck = 1;
    cyc(1);
    rdAck = 0; cfgRdSrc = 1;
    #1;
    chk("R9 read sources cleared together", rdReq, 1'b0);
  endtask

  task automatic tErrHold();
    doReset();
    cfgErrStop = 1; rxLevel = RX_LW'(1); txLevel = TX_LW'(0); shiftBusy = 0;
    cyc(1);
    chk("R10 rd before error", rdReq, 1'b1);
    frameErr = 1;
    cyc(1);
    frameErr = 0;
    chk("R10 rd held off", rdReq, 1'b0);
    chk("R10 wr held off", wrReq, 1'b0);
    cyc(4);
    chk("R10 still held", rdReq | wrReq, 1'b0);
    errClr = 1;
    cyc(1);
    errClr = 0;
    chk("R10 one cycle after clear", rdReq, 1'b0);
    cyc(1);
    chk("R10 rd restored", rdReq, 1'b1);
    chk("R10 wr restored", wrReq, 1'b1);
  endtask

  task automatic tErrIgnored();
    doReset();
    cfgErrStop = 0; rxLevel = RX_LW'(1);
    cyc(1);
    frameErr = 1;
    cyc(1);
    frameErr = 0;
    cyc(1);
    chk("R11 error ignored", rdReq, 1'b1);
  endtask

  task automatic tErrPriority();
    doReset();
    cfgErrStop = 1; rxLevel = RX_LW'(1);
    cyc(1);
    frameErr = 1; errClr = 1;
    cyc(1);
    frameErr = 0; errClr = 0;
    cyc(2);
    chk("R12 set beats clear", rdReq, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    tReset();
    tReadLevel();
    tReadRight();
    tWriteEmpty();
    tWriteRoom();
    tWriteRight();
    tStickyAndAck();
    tClearBoth();
    tErrHold();
    tErrIgnored();
    tErrPriority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule